// File: doc/BRIEF.md
# Next-Line Stream Buffer Prefetcher

This block sits between a level-one instruction cache and the next level of memory and handles instruction-fetch misses. It keeps a side buffer that holds one cache line, its line address and two flags (valid, and busy while that line's fetch is still outstanding). When a miss matches neither the buffer nor an outstanding prefetch, the block asks the lower level for the missed line and then for the line after it. The missed line goes out on the fill port and the following line is parked in the buffer.

When a later miss names the parked line, the block sends that line to the fill port without a new demand fetch and then asks for the next line, so the buffer stays one line ahead of a sequential fetch stream. If the parked line's data has not come back yet, the block waits for it and passes it straight to the fill port. A miss that matches nothing throws away the buffered line. If a prefetch for the discarded line is still outstanding, its response is drained and dropped before the new pair of requests goes out. The lower level accepts requests through a valid/ready handshake and returns one response per request, in request order.

Top module: `nlsb_prefetch`

## Requirements
- R1: After synchronous reset, `miss_ready` is 1 and `fill_valid` and `mem_req_valid` are 0.
- R2: A miss to line A that matches no buffered line issues exactly two lower-level requests, A first and then A+1.
- R3: Each fill presents a line address in `fill_addr` and, in `fill_data`, the data the lower level returned for that address. Every accepted miss to line A produces exactly one fill with `fill_addr` = A.
- R4: A miss to A that matches a buffered line whose data is present fills A from the buffer, issues no request for A, and presents the fill one cycle after the miss is accepted.
- R5: After a buffer hit on line A, exactly one request is issued, for A+1, and that line becomes the buffered line. A run of sequential misses therefore costs one request per line.
- R6: A miss matching the buffered line while its fetch is still outstanding waits for that response, forwards it to the fill port, and then requests the next line.
- R7: A miss that does not match the buffered line invalidates it. A later miss to the discarded line is treated as a full miss with two requests.
- R8: If a non-matching miss arrives while a prefetch is outstanding, the response to that prefetch is dropped and never appears as a fill. Its line is not kept.
- R9: Only one miss is handled at a time: `miss_ready` is 0 in the cycle after a miss is accepted.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, both `mem_req_valid` and `mem_req_addr` hold their values into the next cycle.
- R11: Line addresses wrap modulo 2^ADDR_W, so the line after the all-ones address is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_ready | output | 1 | Block can accept a miss |
| fill_valid | output | 1 | One-cycle fill strobe to the cache |
| fill_addr | output | ADDR_W | Line address being filled |
| fill_data | output | LINE_W | Line contents being filled |
| mem_req_valid | output | 1 | Request to the lower level |
| mem_req_addr | output | ADDR_W | Requested line address |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_rsp_valid | input | 1 | Lower level returns a line (in request order) |
| mem_rsp_data | input | LINE_W | Returned line contents |

## Verification
The bench uses the default 26-bit line address and 64-bit line, so an all-ones miss address brings the wrap from the top line to line 0 within reach. The memory model in the bench has a short default latency and a much longer latency for one chosen address. This opens windows in which a prefetch is still outstanding when the next miss arrives, which exercises forwarding of in-flight data and draining of stale responses. A phase with alternating request backpressure exercises holding the request stable and the demand-before-prefetch order under stalls.

// File: rtl/nlsb_pkg.sv
package nlsb_pkg;

  localparam int unsigned NLSB_ADDR_W = 26;
  localparam int unsigned NLSB_LINE_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEM   = 3'd1,
    ST_PF    = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DRAIN = 3'd4,
    ST_FWD   = 3'd5
  } nlsb_state_t;

endpackage

// File: rtl/nlsb_linebuf.sv
module nlsb_linebuf #(
  parameter int unsigned ADDR_W = nlsb_pkg::NLSB_ADDR_W,
  parameter int unsigned LINE_W = nlsb_pkg::NLSB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_tag_i,
  input  logic              done_i,
  input  logic              wr_i,
  input  logic [LINE_W-1:0] wr_data_i,
  output logic              valid_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [LINE_W-1:0] data_o
);

  logic              valid_q;
  logic              busy_q;
  logic [ADDR_W-1:0] tag_q;
  logic [LINE_W-1:0] data_q;

  // valid and busy: arming wins over clearing
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (done_i) busy_q <= 1'b0;
      if (clr_i)  valid_q <= 1'b0;
      if (arm_i) begin
        valid_q <= 1'b1;
        busy_q  <= 1'b1;
      end
    end
  end

  // payload storage has no reset
  always_ff @(posedge clk) begin
    if (arm_i) tag_q <= arm_tag_i;
    if (wr_i)  data_q <= wr_data_i;
  end

  assign valid_o = valid_q;
  assign busy_o  = busy_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

  // R5: line data is written only into a buffer waiting for its line
  p_wr_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> busy_q);

endmodule

// File: rtl/nlsb_fill.sv
module nlsb_fill #(
  parameter int unsigned ADDR_W = nlsb_pkg::NLSB_ADDR_W,
  parameter int unsigned LINE_W = nlsb_pkg::NLSB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              from_buf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINE_W-1:0] buf_data_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              fill_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [LINE_W-1:0] fill_data_o
);

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= load_i;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      addr_q <= addr_i;
      data_q <= from_buf_i ? buf_data_i : rsp_data_i;
    end
  end

  assign fill_valid_o = vld_q;
  assign fill_addr_o  = addr_q;
  assign fill_data_o  = data_q;

endmodule

// File: rtl/nlsb_ctrl.sv
module nlsb_ctrl
  import nlsb_pkg::*;
#(
  parameter int unsigned ADDR_W = NLSB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              buf_valid,
  input  logic              buf_busy,
  input  logic [ADDR_W-1:0] buf_tag,
  output logic              buf_clr,
  output logic              buf_arm,
  output logic [ADDR_W-1:0] buf_arm_tag,
  output logic              buf_done,
  output logic              buf_wr,
  output logic              fill_load,
  output logic              fill_from_buf,
  output logic [ADDR_W-1:0] fill_addr
);

  localparam logic [ADDR_W-1:0] ONE_LINE = ADDR_W'(1);

  nlsb_state_t       state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              dem_pend_q;
  logic              pf_pend_q;

  logic acc, match, hit_ready, hit_now, dem_rsp, pf_rsp, req_fire;

  assign miss_ready    = (state_q == ST_IDLE);
  assign acc           = miss_valid && miss_ready;
  assign match         = buf_valid && (buf_tag == miss_addr);
  assign dem_rsp       = mem_rsp_valid && dem_pend_q;
  assign pf_rsp        = mem_rsp_valid && !dem_pend_q && pf_pend_q;
  assign hit_ready     = match && !buf_busy;
  assign hit_now       = match && buf_busy && pf_rsp;
  assign mem_req_valid = (state_q == ST_DEM) || (state_q == ST_PF);
  assign mem_req_addr  = req_addr_q;
  assign req_fire      = mem_req_valid && mem_req_ready;

  always_comb begin
    buf_clr       = 1'b0;
    buf_arm       = 1'b0;
    buf_arm_tag   = req_addr_q;
    buf_done      = pf_rsp;
    buf_wr        = pf_rsp && buf_valid && (state_q != ST_FWD);
    fill_load     = dem_rsp;
    fill_from_buf = 1'b0;
    fill_addr     = cur_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          fill_addr = miss_addr;
          if (hit_ready) begin
            fill_load     = 1'b1;
            fill_from_buf = 1'b1;
            buf_clr       = 1'b1;
          end else if (hit_now) begin
            fill_load = 1'b1;
            buf_clr   = 1'b1;
          end else if (!match) begin
            buf_clr = 1'b1;
          end
        end
      end
      ST_PF: begin
        if (req_fire) buf_arm = 1'b1;
      end
      ST_FWD: begin
        if (pf_rsp) begin
          fill_load = 1'b1;
          buf_clr   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      req_addr_q <= '0;
      dem_pend_q <= 1'b0;
      pf_pend_q  <= 1'b0;
    end else begin
      if (dem_rsp) dem_pend_q <= 1'b0;
      if (pf_rsp)  pf_pend_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            cur_q <= miss_addr;
            if (hit_ready || hit_now) begin
              req_addr_q <= miss_addr + ONE_LINE;
              state_q    <= ST_PF;
            end else if (match) begin
              state_q <= ST_FWD;
            end else begin
              req_addr_q <= miss_addr;
              state_q    <= (pf_pend_q && !pf_rsp) ? ST_DRAIN : ST_DEM;
            end
          end
        end
        ST_DRAIN: if (!pf_pend_q) state_q <= ST_DEM;
        ST_DEM: begin
          if (req_fire) begin
            dem_pend_q <= 1'b1;
            req_addr_q <= cur_q + ONE_LINE;
            state_q    <= ST_PF;
          end
        end
        ST_PF: begin
          if (req_fire) begin
            pf_pend_q <= 1'b1;
            state_q   <= ST_WAIT;
          end
        end
        ST_WAIT: if (!dem_pend_q) state_q <= ST_IDLE;
        ST_FWD: begin
          if (pf_rsp) begin
            req_addr_q <= cur_q + ONE_LINE;
            state_q    <= ST_PF;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a taken miss closes the intake for the next cycle
  p_single_miss_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> !miss_ready);

  // R10: a stalled request holds
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: the accepted demand request is followed by the next line
  p_pair_order_r2: assert property (@(posedge clk) disable iff (rst)
    (req_fire && state_q == ST_DEM) |=>
      (mem_req_valid && mem_req_addr == $past(mem_req_addr) + ONE_LINE));

  // R7: a non-matching miss leaves no buffered line behind
  p_stale_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && !match) |=> !buf_valid);

endmodule

// File: rtl/nlsb_prefetch.sv
module nlsb_prefetch #(
  parameter int unsigned ADDR_W = nlsb_pkg::NLSB_ADDR_W,
  parameter int unsigned LINE_W = nlsb_pkg::NLSB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  logic              buf_valid, buf_busy, buf_clr, buf_arm, buf_done, buf_wr;
  logic [ADDR_W-1:0] buf_tag, buf_arm_tag;
  logic [LINE_W-1:0] buf_data;
  logic              f_load, f_from_buf;
  logic [ADDR_W-1:0] f_addr;

  nlsb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_addr     (miss_addr),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .buf_valid     (buf_valid),
    .buf_busy      (buf_busy),
    .buf_tag       (buf_tag),
    .buf_clr       (buf_clr),
    .buf_arm       (buf_arm),
    .buf_arm_tag   (buf_arm_tag),
    .buf_done      (buf_done),
    .buf_wr        (buf_wr),
    .fill_load     (f_load),
    .fill_from_buf (f_from_buf),
    .fill_addr     (f_addr)
  );

  nlsb_linebuf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (buf_clr),
    .arm_i     (buf_arm),
    .arm_tag_i (buf_arm_tag),
    .done_i    (buf_done),
    .wr_i      (buf_wr),
    .wr_data_i (mem_rsp_data),
    .valid_o   (buf_valid),
    .busy_o    (buf_busy),
    .tag_o     (buf_tag),
    .data_o    (buf_data)
  );

  nlsb_fill #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fill (
    .clk          (clk),
    .rst          (rst),
    .load_i       (f_load),
    .from_buf_i   (f_from_buf),
    .addr_i       (f_addr),
    .buf_data_i   (buf_data),
    .rsp_data_i   (mem_rsp_data),
    .fill_valid_o (fill_valid),
    .fill_addr_o  (fill_addr),
    .fill_data_o  (fill_data)
  );

  // R4: a hit on a present line fills in the next cycle
  p_hit_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready && buf_valid && !buf_busy && buf_tag == miss_addr)
      |=> (fill_valid && fill_addr == $past(miss_addr)));

  // R6: a forwarded in-flight line reaches the fill port from the response
  p_fwd_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (f_load && !f_from_buf && mem_rsp_valid) |=>
      (fill_valid && fill_data == $past(mem_rsp_data)));

endmodule

// File: tb/tb_nlsb_prefetch.sv
module tb_nlsb_prefetch;

  localparam int AW   = 26;
  localparam int LW   = 64;
  localparam int LAT  = 3;
  localparam int SLOW = 25;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [LW-1:0] fill_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready = 1'b1;
  logic          mem_rsp_valid = 1'b0;
  logic [LW-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  nlsb_prefetch #(.ADDR_W(AW), .LINE_W(LW)) dut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state
  logic [AW-1:0] exp_req[$];
  string         exp_req_tag[$];
  logic [AW-1:0] exp_fill[$];
  string         exp_fill_tag[$];
  logic [AW-1:0] pend_addr[$];
  int            pend_due[$];
  bit            ref_valid = 1'b0;
  logic [AW-1:0] ref_tag = '0;
  bit            slow_en = 1'b0;
  logic [AW-1:0] slow_addr = '0;
  bit            ready_mode = 1'b0;
  bit            prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [LW-1:0] line_of(logic [AW-1:0] a);
    return {6'h2a, ~a, 6'h15, a};
  endfunction

  task automatic chk(bit ok, string tag, logic [LW-1:0] got, logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // per-clock comparison, lower-level model
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      mem_rsp_valid = 1'b0;
      prev_stall    = 1'b0;
    end else begin
      mem_req_ready = ready_mode ? ((cyc % 2) == 0) : 1'b1;
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R10 held request",
            LW'(mem_req_addr), LW'(prev_addr));
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) begin
          chk(1'b0, "R2 unexpected request", LW'(mem_req_addr), '0);
        end else begin
          chk(mem_req_addr == exp_req[0], exp_req_tag[0], LW'(mem_req_addr), LW'(exp_req[0]));
          void'(exp_req.pop_front());
          void'(exp_req_tag.pop_front());
        end
        pend_addr.push_back(mem_req_addr);
        pend_due.push_back(cyc + ((slow_en && mem_req_addr == slow_addr) ? SLOW : LAT));
      end
      if (fill_valid) begin
        if (exp_fill.size() == 0) begin
          chk(1'b0, "R8 unexpected fill", LW'(fill_addr), '0);
        end else begin
          chk(fill_addr == exp_fill[0], exp_fill_tag[0], LW'(fill_addr), LW'(exp_fill[0]));
          chk(fill_data == line_of(exp_fill[0]), "R3 fill data", fill_data, line_of(exp_fill[0]));
          void'(exp_fill.pop_front());
          void'(exp_fill_tag.pop_front());
        end
      end
      if (pend_addr.size() > 0 && cyc >= pend_due[0]) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_of(pend_addr[0]);
        void'(pend_addr.pop_front());
        void'(pend_due.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_miss(logic [AW-1:0] a, string tag);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    if (ref_valid && ref_tag == a) begin
      exp_fill.push_back(a);      exp_fill_tag.push_back({tag, " hit fill"});
      exp_req.push_back(a + 1'b1); exp_req_tag.push_back({tag, " next prefetch"});
    end else begin
      exp_req.push_back(a);        exp_req_tag.push_back({tag, " demand request"});
      exp_req.push_back(a + 1'b1); exp_req_tag.push_back({tag, " pair prefetch"});
      exp_fill.push_back(a);       exp_fill_tag.push_back({tag, " demand fill"});
    end
    ref_valid = 1'b1;
    ref_tag   = a + 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(!miss_ready, "R9 intake closed after accept", LW'(miss_ready), '0);
  endtask

  task automatic settle();
    for (int i = 0; i < 400; i++) begin
      if (exp_req.size() == 0 && exp_fill.size() == 0 && pend_addr.size() == 0 && miss_ready)
        break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(miss_ready == 1'b1, "R1 miss_ready", LW'(miss_ready), 1);
    chk(fill_valid == 1'b0, "R1 fill_valid", LW'(fill_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", LW'(mem_req_valid), 0);

    do_miss(26'd100, "R2");
    settle();
    do_miss(26'd101, "R4");
    settle();
    do_miss(26'd102, "R5");
    do_miss(26'd103, "R5");
    do_miss(26'd104, "R5");
    settle();

    do_miss(26'd500, "R7");
    do_miss(26'd600, "R7");
    do_miss(26'd501, "R7");
    settle();

    slow_en = 1'b1; slow_addr = 26'd801;
    do_miss(26'd800, "R6");
    do_miss(26'd801, "R6");
    settle();

    slow_addr = 26'd901;
    do_miss(26'd900, "R8");
    do_miss(26'd950, "R8");
    do_miss(26'd901, "R8");
    settle();
    slow_en = 1'b0;

    ready_mode = 1'b1;
    do_miss(26'd1200, "R10");
    do_miss(26'd1201, "R10");
    do_miss(26'd1300, "R10");
    settle();
    ready_mode = 1'b0;

    do_miss({AW{1'b1}}, "R11");
    do_miss(26'd0, "R11");
    settle();

    chk(exp_req.size() == 0, "R5 leftover requests", LW'(exp_req.size()), 0);
    chk(exp_fill.size() == 0, "R3 leftover fills", LW'(exp_fill.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule